// File: doc/BRIEF.md
# Triangle Primitive Assembler

This block sits after vertex transformation and groups a stream of vertices into triangles. Each vertex carries a payload that the block does not interpret. A 2-bit topology setting selects how consecutive vertices are combined. In the independent-triangle modes, every three vertices form one triangle. In strip mode, each new vertex closes a triangle with the two vertices before it. In fan mode, every triangle shares the first vertex of the run as a pivot.

The block holds only two earlier vertices in a two-slot history. Each finished triangle goes into an output register behind a valid/ready handshake. A configuration strobe loads a new topology and clears the history. A restart strobe clears the history without touching the topology. A vertex that would complete a triangle is refused while the output register is full and not being drained, so back-pressure never drops or duplicates a vertex.

Top module: `prim_tri_assembler`

## Requirements
- R1: After reset the output holds no triangle (`tri_valid` low), `vtx_ready` is high, and the topology is the independent-triangle code 0.
- R2: With topology code 0, the vertices accepted since the last clear form triangles in groups of three, in arrival order. For each group, the triangle (v0, v1, v2) is the first, second and third vertex of that group.
- R3: Topology code 3 produces exactly the same triangles as code 0.
- R4: With topology code 1 (strip), the n-th accepted vertex (n counted from 0 since the last clear, n at least 2) emits a triangle. Its v0 is whichever of vertices n-2 and n-1 has an even number, its v1 is the one with an odd number, and its v2 is vertex n.
- R5: With topology code 2 (fan), the n-th accepted vertex (n at least 2) emits the triangle (vertex 0, vertex n-1, vertex n).
- R6: In strip and fan modes, the first two vertices after a clear emit no triangle.
- R7: A cycle with `cfg_load` high latches `cfg_topo` as the new topology and clears the vertex count, so the next vertex is numbered 0.
- R8: A cycle with `prim_restart` high clears the vertex count but keeps the current topology.
- R9: While `tri_valid` is high and `tri_ready` is low, the output triangle stays unchanged. Every accepted vertex is counted exactly once, whatever the back-pressure pattern.
- R10: During a cycle in which `cfg_load` or `prim_restart` is high, `vtx_ready` is low and no vertex is taken.
- R11: A triangle appears on `tri_valid` in the cycle after the edge at which its last vertex is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe: load `cfg_topo` and clear the history |
| cfg_topo | input | 2 | Topology: 0 triangles, 1 strip, 2 fan, 3 treated as 0 |
| prim_restart | input | 1 | Strobe: clear the history, keep the topology |
| vtx_valid | input | 1 | Vertex offered |
| vtx_ready | output | 1 | Vertex taken at this edge if valid |
| vtx_data | input | VTX_W | Opaque vertex payload |
| tri_valid | output | 1 | Triangle available |
| tri_ready | input | 1 | Consumer takes the triangle |
| tri_v0 | output | VTX_W | First triangle vertex |
| tri_v1 | output | VTX_W | Second triangle vertex |
| tri_v2 | output | VTX_W | Third triangle vertex |

## Verification
The bench sweeps all four topology codes against stream lengths 0 to 9 and four back-pressure patterns. Every vertex payload is distinct, so each emitted triangle is compared against the arithmetic expectation and any wrong slot, order or count shows up directly. Short streams show that strip and fan need two vertices to prime, and that leftover partial groups in triangle mode are dropped on reconfiguration. Stalling patterns show that vertices are neither lost nor reused, and that a held triangle stays stable. A strip stream split by a restart strobe shows that restarting clears the history but keeps the strip ordering. Code 3 is compared against the same expectations as code 0.

// File: rtl/prim_asm_pkg.sv
package prim_asm_pkg;

    typedef enum logic [1:0] {
        TOPO_TRIS   = 2'd0,
        TOPO_STRIP  = 2'd1,
        TOPO_FAN    = 2'd2,
        TOPO_SHADER = 2'd3
    } topo_e;

    localparam int SLOT_COUNT = 2;
    localparam int IDX_W      = 2;

    typedef struct packed {
        topo_e              mode;
        logic [IDX_W-1:0]   idx;
        logic               primed;
    } asm_state_t;

    function automatic logic groups_of_three(input topo_e t);
        return (t == TOPO_TRIS) || (t == TOPO_SHADER);
    endfunction

    function automatic logic [IDX_W-1:0] advance_idx(input topo_e t,
                                                     input logic [IDX_W-1:0] i);
        logic [IDX_W-1:0] r;
        if (groups_of_three(t))
            r = (i == IDX_W'(2)) ? '0 : i + IDX_W'(1);
        else if (t == TOPO_STRIP)
            r = {1'b0, ~i[0]};
        else
            r = IDX_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
    import prim_asm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_topo,
    input  logic             prim_restart,
    input  logic             vtx_fire,
    output topo_e            mode,
    output logic [IDX_W-1:0] idx,
    output logic             primed,
    output logic             emit_now,
    output logic             store_en,
    output logic             store_sel
);
    asm_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode   <= TOPO_TRIS;
            st_q.idx    <= '0;
            st_q.primed <= 1'b0;
        end else if (cfg_load) begin
            st_q.mode   <= topo_e'(cfg_topo);
            st_q.idx    <= '0;
            st_q.primed <= 1'b0;
        end else if (prim_restart) begin
            st_q.idx    <= '0;
            st_q.primed <= 1'b0;
        end else if (vtx_fire) begin
            st_q.idx <= advance_idx(st_q.mode, st_q.idx);
            if (!groups_of_three(st_q.mode) && st_q.idx == IDX_W'(1))
                st_q.primed <= 1'b1;
        end
    end

    always_comb begin
        mode      = st_q.mode;
        idx       = st_q.idx;
        primed    = st_q.primed;
        emit_now  = groups_of_three(st_q.mode) ? (st_q.idx == IDX_W'(2)) : st_q.primed;
        store_en  = vtx_fire && !(groups_of_three(st_q.mode) && st_q.idx == IDX_W'(2));
        store_sel = st_q.idx[0];
    end
endmodule

// File: rtl/pa_history.sv
module pa_history
    import prim_asm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] slot0,
    output logic [W-1:0] slot1
);
    logic [W-1:0] slots_q [SLOT_COUNT];

    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots_q[s] <= '0;
            else if (wr_en && (int'(wr_sel) == s))
                slots_q[s] <= wr_data;
        end
    end

    assign slot0 = slots_q[0];
    assign slot1 = slots_q[1];
endmodule

// File: rtl/pa_tri_reg.sv
module pa_tri_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] in_v0,
    input  logic [W-1:0] in_v1,
    input  logic [W-1:0] in_v2,
    output logic         free,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_v0,
    output logic [W-1:0] out_v1,
    output logic [W-1:0] out_v2
);
    logic valid_q;
    logic [W-1:0] v0_q, v1_q, v2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            v0_q    <= '0;
            v1_q    <= '0;
            v2_q    <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            v0_q    <= in_v0;
            v1_q    <= in_v1;
            v2_q    <= in_v2;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign free      = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_v0    = v0_q;
    assign out_v1    = v1_q;
    assign out_v2    = v2_q;
endmodule

// File: rtl/prim_tri_assembler.sv
module prim_tri_assembler
    import prim_asm_pkg::*;
#(
    parameter int VTX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_topo,
    input  logic             prim_restart,
    input  logic             vtx_valid,
    output logic             vtx_ready,
    input  logic [VTX_W-1:0] vtx_data,
    output logic             tri_valid,
    input  logic             tri_ready,
    output logic [VTX_W-1:0] tri_v0,
    output logic [VTX_W-1:0] tri_v1,
    output logic [VTX_W-1:0] tri_v2
);
    topo_e            mode_w;
    logic [IDX_W-1:0] idx_w;
    logic             primed_w;
    logic             emit_w, store_en_w, store_sel_w;
    logic             out_free_w, fire_w;
    logic [VTX_W-1:0] slot0_w, slot1_w;

    assign vtx_ready = !(cfg_load || prim_restart) && (!emit_w || out_free_w);
    assign fire_w    = vtx_valid && vtx_ready;

    pa_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_load     (cfg_load),
        .cfg_topo     (cfg_topo),
        .prim_restart (prim_restart),
        .vtx_fire     (fire_w),
        .mode         (mode_w),
        .idx          (idx_w),
        .primed       (primed_w),
        .emit_now     (emit_w),
        .store_en     (store_en_w),
        .store_sel    (store_sel_w)
    );

    pa_history #(.W(VTX_W)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_en_w),
        .wr_sel  (store_sel_w),
        .wr_data (vtx_data),
        .slot0   (slot0_w),
        .slot1   (slot1_w)
    );

    pa_tri_reg #(.W(VTX_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (fire_w && emit_w),
        .in_v0     (slot0_w),
        .in_v1     (slot1_w),
        .in_v2     (vtx_data),
        .free      (out_free_w),
        .out_valid (tri_valid),
        .out_ready (tri_ready),
        .out_v0    (tri_v0),
        .out_v1    (tri_v1),
        .out_v2    (tri_v2)
    );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cfg_load,
    input logic         prim_restart,
    input logic         vtx_valid,
    input logic         vtx_ready,
    input logic         tri_valid,
    input logic         tri_ready,
    input logic [W-1:0] tri_v0,
    input logic [W-1:0] tri_v1,
    input logic [W-1:0] tri_v2,
    input logic [1:0]   mode,
    input logic [1:0]   idx,
    input logic         primed
);
    logic fire;
    assign fire = vtx_valid && vtx_ready;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tri_valid && mode == 2'd0 && vtx_ready));

    p_held_tri_r9: assert property (@(posedge clk) disable iff (rst)
        (tri_valid && !tri_ready) |=> (tri_valid && $stable(tri_v0)
                                       && $stable(tri_v1) && $stable(tri_v2)));

    p_strobe_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_load || prim_restart) |-> !vtx_ready);

    p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (prim_restart && !cfg_load) |=> (idx == 2'd0 && !primed && $stable(mode)));

    p_load_clears_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (idx == 2'd0 && !primed));

    p_strip_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && mode == 2'd1) |=> (idx[0] != $past(idx[0])));

    p_fan_pivot_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && mode == 2'd2) |=> (idx == 2'd1));

    p_third_emits_r11: assert property (@(posedge clk) disable iff (rst)
        (fire && (mode == 2'd0 || mode == 2'd3) && idx == 2'd2) |=> tri_valid);

    p_unprimed_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && (mode == 2'd1 || mode == 2'd2) && !primed && !tri_valid) |=> !tri_valid);
endmodule

bind prim_tri_assembler pa_checker #(.W(VTX_W)) u_pa_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_load     (cfg_load),
    .prim_restart (prim_restart),
    .vtx_valid    (vtx_valid),
    .vtx_ready    (vtx_ready),
    .tri_valid    (tri_valid),
    .tri_ready    (tri_ready),
    .tri_v0       (tri_v0),
    .tri_v1       (tri_v1),
    .tri_v2       (tri_v2),
    .mode         (mode_w),
    .idx          (idx_w),
    .primed       (primed_w)
);

// File: tb/test_prim_tri_assembler.sv
module test_prim_tri_assembler;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic [1:0] cfg_topo = 2'd0;
    logic prim_restart = 1'b0;
    logic vtx_valid = 1'b0;
    logic vtx_ready;
    logic [W-1:0] vtx_data = '0;
    logic tri_valid;
    logic tri_ready = 1'b1;
    logic [W-1:0] tri_v0, tri_v1, tri_v2;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int base   = 0;

    always #10 clk = ~clk;

    prim_tri_assembler #(.VTX_W(W)) i_prim_tri_assembler (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_topo(cfg_topo),
        .prim_restart(prim_restart), .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
        .vtx_data(vtx_data), .tri_valid(tri_valid), .tri_ready(tri_ready),
        .tri_v0(tri_v0), .tri_v1(tri_v1), .tri_v2(tri_v2)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tri_count(input int topo, input int n);
        if (topo == 0 || topo == 3) return n / 3;
        return (n >= 2) ? n - 2 : 0;
    endfunction

    // Expected vertex numbers (relative to the stream start) of triangle k.
    function automatic void expect_tri(input int topo, input int k,
                                       output int a, output int b, output int c);
        int n;
        if (topo == 0 || topo == 3) begin
            a = 3*k; b = 3*k + 1; c = 3*k + 2;
        end else if (topo == 1) begin
            n = k + 2;
            a = (n % 2 == 0) ? n - 2 : n - 1;
            b = (n % 2 == 0) ? n - 1 : n - 2;
            c = n;
        end else begin
            n = k + 2;
            a = 0; b = n - 1; c = n;
        end
    endfunction

    // ctl: 0 = no strobe, 1 = cfg_load, 2 = prim_restart
    task automatic run_stream(input int topo, input int n, input int stall, input int ctl);
        int sent = 0, got = 0, cyc = 0, exp_n;
        bit held = 0;
        int h0 = 0, h1 = 0, h2 = 0;
        int ea, eb, ec;
        string tg;
        exp_n = tri_count(topo, n);
        tg = (topo == 0) ? "R2" : (topo == 3) ? "R3" : (topo == 1) ? "R4" : "R5";
        @(negedge clk);
        if (ctl != 0) begin
            cfg_load     = (ctl == 1);
            prim_restart = (ctl == 2);
            cfg_topo     = 2'(topo);
            vtx_valid    = 1'b1;
            vtx_data     = 16'hFFFF;
            tri_ready    = 1'b1;
            #1;
            check(vtx_ready == 1'b0, "R10 strobe blocks vertex", int'(vtx_ready), 0);
            @(negedge clk);
            cfg_load = 1'b0; prim_restart = 1'b0; vtx_valid = 1'b0;
        end
        while ((sent < n || got < exp_n) && cyc < 400) begin
            vtx_valid = (sent < n);
            vtx_data  = W'(base + sent);
            tri_ready = (stall == 0) || ((cyc % (stall + 1)) != 0);
            #1;
            if (held) begin
                check(tri_valid && tri_v0 == W'(h0) && tri_v1 == W'(h1) && tri_v2 == W'(h2),
                      "R9 held triangle stable", int'(tri_v0), h0);
            end
            held = 0;
            if (tri_valid && !tri_ready) begin
                held = 1; h0 = int'(tri_v0); h1 = int'(tri_v1); h2 = int'(tri_v2);
            end
            if (tri_valid && tri_ready) begin
                if (got >= exp_n) begin
                    check(0, "R6 extra triangle", got + 1, exp_n);
                end else begin
                    expect_tri(topo, got, ea, eb, ec);
                    check(tri_v0 == W'(base + ea), {tg, " v0"}, int'(tri_v0), base + ea);
                    check(tri_v1 == W'(base + eb), {tg, " v1"}, int'(tri_v1), base + eb);
                    check(tri_v2 == W'(base + ec), {tg, " v2"}, int'(tri_v2), base + ec);
                end
                got++;
            end
            if (vtx_valid && vtx_ready) sent++;
            @(negedge clk);
            cyc++;
        end
        vtx_valid = 1'b0;
        tri_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            if (tri_valid) got++;
            @(negedge clk);
        end
        check(got == exp_n, "R9 triangle count", got, exp_n);
        check(sent == n, "R9 vertices accepted", sent, n);
        base += 64;
    endtask

    // R11: triangle visible right after the edge that takes its last vertex
    task automatic latency_probe();
        @(negedge clk);
        cfg_load = 1'b1; cfg_topo = 2'd0;
        @(negedge clk);
        cfg_load = 1'b0; tri_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            vtx_valid = 1'b1; vtx_data = W'(500 + i);
            #1;
            check(tri_valid == 1'b0, "R11 no early triangle", int'(tri_valid), 0);
            @(negedge clk);
        end
        vtx_valid = 1'b0;
        #1;
        check(tri_valid == 1'b1 && tri_v2 == W'(502), "R11 one-cycle latency",
              int'(tri_v2), 502);
        tri_ready = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(tri_valid == 1'b0, "R1 tri_valid after reset", int'(tri_valid), 0);
        check(vtx_ready == 1'b1, "R1 vtx_ready after reset", int'(vtx_ready), 1);
        // R1: default topology is code 0 without any configuration
        run_stream(0, 7, 0, 0);
        latency_probe();
        // R8: strip split by a restart keeps strip ordering
        run_stream(1, 5, 1, 1);
        run_stream(1, 6, 2, 2);
        run_stream(2, 4, 0, 1);
        run_stream(2, 5, 3, 2);
        // R7 sweep: every reconfiguration starts from vertex 0
        for (int t = 0; t < 4; t++)
            for (int n = 0; n < 10; n++)
                for (int s = 0; s < 4; s++)
                    run_stream(t, n, s, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule